// File: doc/BRIEF.md
# UART Receive Timeout and Interrupt Status

This block collects the interrupt flags of a UART receive path and produces a receive-timeout condition on its own. It watches a bit-period tick from the baud generator, the empty flag of the receive FIFO, and strobes for each character written into the FIFO and each read from it. When the FIFO holds data and the line stays quiet for a set number of bit periods, the timeout flag rises. This lets software or a DMA engine collect a partial block of characters that never reaches a FIFO trigger level.

The other interrupt sources of the UART arrive as single-cycle event strobes and are latched beside the timeout flag. The raw flags, the mask and the combined interrupt line are all registered. Software clears flags by writing ones to a clear strobe. It sets which flags reach the interrupt line by writing the mask. The timeout flag also drops by itself once the receive FIFO is empty.

Top module: `uart_rxto_irq`

## Requirements
- R1: After reset, `raw_o`, `masked_o` and `irq_o` are all zero and the mask is zero.
- R2: Bit 0 of `raw_o` is the receive timeout. It becomes 1 one clock after the IDLE_BITS-th consecutive `bit_tick` seen while `fifo_empty` is 0 and no `char_rx` or `fifo_rd` has occurred, and it stays 0 after IDLE_BITS-1 such ticks.
- R3: A `char_rx` or `fifo_rd` pulse restarts the idle count, so that a full IDLE_BITS further ticks are needed before the timeout sets.
- R4: While `fifo_empty` is 1, bit 0 of `raw_o` clears one clock later and ticks are not counted.
- R5: A `clr_we` pulse clears, one clock later, every raw bit whose `wdata` bit is 1. Raw bits whose `wdata` bit is 0 keep their value.
- R6: `masked_o` equals `raw_o` AND the mask, and `irq_o` is the OR of all `masked_o` bits. Both update in the same cycle as `raw_o`.
- R7: After the timeout flag is cleared by a write while the FIFO still holds data, it does not set again until another full IDLE_BITS ticks have elapsed.
- R8: A pulse on `evt_i[k]` sets bit k+1 of `raw_o` one clock later.
- R9: When an event and a clear of the same bit fall in the same cycle, the bit is 1 afterwards.
- R10: A `mask_we` pulse loads the mask from `wdata` one clock later and leaves `raw_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One-cycle pulse per serial bit period |
| fifo_empty | input | 1 | Receive FIFO (or holding register) is empty |
| char_rx | input | 1 | A character was pushed into the receive FIFO |
| fifo_rd | input | 1 | A character was read from the receive FIFO |
| evt_i | input | EV_W | Other raw interrupt event strobes, bit k maps to raw bit k+1 |
| mask_we | input | 1 | Load the mask from `wdata` |
| clr_we | input | 1 | Write-one-to-clear strobe using `wdata` |
| wdata | input | EV_W+1 | Write data for mask and clear writes |
| raw_o | output | EV_W+1 | Raw interrupt status, bit 0 is receive timeout |
| masked_o | output | EV_W+1 | Raw status gated by the mask |
| irq_o | output | 1 | OR of all masked status bits |

## Verification
The bench builds the block with IDLE_BITS set to 6 and EV_W set to 3. This brings the count boundary, the restart by a character or a read, and re-arming after a clear within a few dozen cycles each. Three event sources, together with the timeout bit, make a four-bit vector. That is wide enough to show that a clear write touches only the bits written as one, and that an event and a clear on the same bit resolve in favour of the event.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  // Position of the receive timeout flag in the status vector.
  localparam int unsigned TO_IDX = 0;

  // Raw status position of event strobe k.
  function automatic int unsigned evt_pos(input int unsigned k);
    return k + 1;
  endfunction

endpackage

// File: rtl/rxto_idle_timer.sv
module rxto_idle_timer #(
  parameter int unsigned IDLE_BITS = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_tick,
  input  logic fifo_empty,
  input  logic char_rx,
  input  logic fifo_rd,
  input  logic to_clr,
  output logic fire
);
  localparam int unsigned CNT_W = (IDLE_BITS > 2) ? $clog2(IDLE_BITS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(IDLE_BITS - 1);

  logic [CNT_W-1:0] cnt;
  logic             fired;
  logic             restart;

  assign restart = fifo_empty | char_rx | fifo_rd;
  assign fire    = bit_tick & ~fired & ~restart & (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      fired <= 1'b0;
    end else if (restart) begin
      cnt   <= '0;
      fired <= 1'b0;
    end else if (fire) begin
      cnt   <= '0;
      fired <= 1'b1;
    end else if (to_clr) begin
      cnt   <= '0;
      fired <= 1'b0;
    end else if (bit_tick && !fired) begin
      cnt <= cnt + 1'b1;
    end
  end

  // R3: a character or a read leaves the count at zero.
  a_r3_restart_zero: assert property (@(posedge clk) disable iff (rst)
    (char_rx || fifo_rd) |=> (cnt == '0));

  // R4: nothing fires while the FIFO is empty.
  a_r4_no_fire_empty: assert property (@(posedge clk) disable iff (rst)
    fifo_empty |-> !fire);

  // R7: once fired, no second fire without a re-arm.
  a_r7_single_fire: assert property (@(posedge clk) disable iff (rst)
    (fire && !to_clr) |=> !fire);

endmodule

// File: rtl/irq_flag.sv
module irq_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic d,
  output logic q
);
  // A new event takes priority over a clear in the same cycle.
  assign d = set | (q & ~clr);

  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= d;
  end

  // R9: an event always leaves the flag set.
  a_r9_set_wins: assert property (@(posedge clk) disable iff (rst)
    set |=> q);

  // R5: a clear without an event leaves the flag low.
  a_r5_clear_drops: assert property (@(posedge clk) disable iff (rst)
    (clr && !set) |=> !q);

  // R5: with neither input, the flag holds.
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    (!clr && !set) |=> $stable(q));

endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] d,
  output logic [W-1:0] q
);
  assign d = we ? wdata : q;

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end

  // R10: the mask only moves on a write.
  a_r10_mask_hold: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(q));

endmodule

// File: rtl/uart_rxto_irq.sv
module uart_rxto_irq
  import uart_irq_pkg::*;
#(
  parameter int unsigned IDLE_BITS = 32,
  parameter int unsigned EV_W      = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bit_tick,
  input  logic          fifo_empty,
  input  logic          char_rx,
  input  logic          fifo_rd,
  input  logic [EV_W-1:0] evt_i,
  input  logic          mask_we,
  input  logic          clr_we,
  input  logic [EV_W:0] wdata,
  output logic [EV_W:0] raw_o,
  output logic [EV_W:0] masked_o,
  output logic          irq_o
);
  localparam int unsigned N = EV_W + 1;

  logic [N-1:0] set_v;
  logic [N-1:0] clr_v;
  logic [N-1:0] raw_d;
  logic [N-1:0] raw_q;
  logic [N-1:0] mask_d;
  logic [N-1:0] mask_q;
  logic         to_fire;
  logic         to_wclr;

  assign to_wclr = clr_we & wdata[TO_IDX];

  rxto_idle_timer #(.IDLE_BITS(IDLE_BITS)) u_timer (
    .clk        (clk),
    .rst        (rst),
    .bit_tick   (bit_tick),
    .fifo_empty (fifo_empty),
    .char_rx    (char_rx),
    .fifo_rd    (fifo_rd),
    .to_clr     (to_wclr),
    .fire       (to_fire)
  );

  // Timeout flag: set by the timer, cleared by a write or an empty FIFO.
  assign set_v[TO_IDX] = to_fire;
  assign clr_v[TO_IDX] = to_wclr | fifo_empty;

  // Event flags: set by their strobes, cleared only by writes.
  for (genvar k = 0; k < EV_W; k++) begin : g_evt
    assign set_v[evt_pos(k)] = evt_i[k];
    assign clr_v[evt_pos(k)] = clr_we & wdata[evt_pos(k)];
  end

  for (genvar b = 0; b < N; b++) begin : g_flag
    irq_flag u_flag (
      .clk (clk),
      .rst (rst),
      .set (set_v[b]),
      .clr (clr_v[b]),
      .d   (raw_d[b]),
      .q   (raw_q[b])
    );
  end

  irq_mask_reg #(.W(N)) u_mask (
    .clk   (clk),
    .rst   (rst),
    .we    (mask_we),
    .wdata (wdata),
    .d     (mask_d),
    .q     (mask_q)
  );

  // Masked vector and line are registered from next-state values so that
  // they move in the same cycle as the raw flags.
  always_ff @(posedge clk) begin
    if (rst) begin
      masked_o <= '0;
      irq_o    <= 1'b0;
    end else begin
      masked_o <= raw_d & mask_d;
      irq_o    <= |(raw_d & mask_d);
    end
  end

  assign raw_o = raw_q;

  // R6: masked vector agrees with the raw flags and the mask.
  a_r6_masked: assert property (@(posedge clk) disable iff (rst)
    masked_o == (raw_o & mask_q));

  // R6: the line is the OR of the masked vector.
  a_r6_line: assert property (@(posedge clk) disable iff (rst)
    irq_o == (|masked_o));

  // R2: the timeout only rises while the FIFO holds data.
  a_r2_rise_needs_data: assert property (@(posedge clk) disable iff (rst)
    $rose(raw_o[TO_IDX]) |-> $past(!fifo_empty && bit_tick));

  // R4: an empty FIFO takes the timeout down.
  a_r4_empty_clears: assert property (@(posedge clk) disable iff (rst)
    fifo_empty |=> !raw_o[TO_IDX]);

  // R8: every event strobe shows up in the raw vector.
  for (genvar k = 0; k < EV_W; k++) begin : g_chk
    a_r8_event_sets: assert property (@(posedge clk) disable iff (rst)
      evt_i[k] |=> raw_o[evt_pos(k)]);
  end

endmodule

// File: tb/uart_rxto_irq_test.sv
module uart_rxto_irq_test;
  localparam int CLK_PERIOD = 10;
  localparam int IDLE = 6;
  localparam int EVW  = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_tick = 1'b0;
  logic fifo_empty = 1'b1;
  logic char_rx = 1'b0;
  logic fifo_rd = 1'b0;
  logic [EVW-1:0] evt_i = '0;
  logic mask_we = 1'b0;
  logic clr_we = 1'b0;
  logic [EVW:0] wdata = '0;
  logic [EVW:0] raw_o;
  logic [EVW:0] masked_o;
  logic irq_o;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_rxto_irq #(.IDLE_BITS(IDLE), .EV_W(EVW)) uut (
    .clk (clk), .rst (rst), .bit_tick (bit_tick), .fifo_empty (fifo_empty),
    .char_rx (char_rx), .fifo_rd (fifo_rd), .evt_i (evt_i),
    .mask_we (mask_we), .clr_we (clr_we), .wdata (wdata),
    .raw_o (raw_o), .masked_o (masked_o), .irq_o (irq_o)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // One clock with the inputs driven at the falling edge, then back to idle.
  task automatic step();
    @(negedge clk);
    bit_tick = 1'b0; char_rx = 1'b0; fifo_rd = 1'b0;
    evt_i = '0; mask_we = 1'b0; clr_we = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      bit_tick = 1'b1;
      step();
      step();
    end
  endtask

  task automatic wr_mask(input logic [EVW:0] v);
    mask_we = 1'b1; wdata = v; step();
  endtask

  task automatic wr_clr(input logic [EVW:0] v);
    clr_we = 1'b1; wdata = v; step();
  endtask

  task automatic t_reset();
    check("R1 raw",    8'(raw_o), 8'h0);
    check("R1 masked", 8'(masked_o), 8'h0);
    check("R1 irq",    8'(irq_o), 8'h0);
  endtask

  task automatic t_events();
    evt_i = 3'b010; step();
    check("R8 evt1 raw", 8'(raw_o), 8'h4);
    check("R6 unmasked line", 8'(irq_o), 8'h0);
    wr_mask(4'b0100);
    check("R10 raw after mask", 8'(raw_o), 8'h4);
    check("R6 masked", 8'(masked_o), 8'h4);
    check("R6 line", 8'(irq_o), 8'h1);
  endtask

  task automatic t_w1c();
    evt_i = 3'b101; step();
    check("R8 evt0/evt2 raw", 8'(raw_o), 8'he);
    wr_clr(4'b0010);
    check("R5 partial clear", 8'(raw_o), 8'hc);
    clr_we = 1'b1; wdata = 4'b1000; evt_i = 3'b100; step();
    check("R9 event beats clear", 8'(raw_o), 8'hc);
    wr_clr(4'b1111);
    check("R5 clear all", 8'(raw_o), 8'h0);
    check("R6 line low", 8'(irq_o), 8'h0);
  endtask

  task automatic t_timeout();
    wr_mask(4'b0001);
    fifo_empty = 1'b0;
    char_rx = 1'b1; step();
    ticks(IDLE - 1);
    check("R2 one short", 8'(raw_o), 8'h0);
    ticks(1);
    check("R2 timeout set", 8'(raw_o), 8'h1);
    check("R6 timeout line", 8'(irq_o), 8'h1);
  endtask

  task automatic t_restart();
    fifo_empty = 1'b1; step();
    check("R4 empty clears", 8'(raw_o), 8'h0);
    ticks(2 * IDLE);
    check("R4 no count while empty", 8'(raw_o), 8'h0);
    fifo_empty = 1'b0; char_rx = 1'b1; step();
    ticks(IDLE - 1);
    char_rx = 1'b1; step();
    ticks(IDLE - 1);
    check("R3 char restarts", 8'(raw_o), 8'h0);
    fifo_rd = 1'b1; step();
    ticks(IDLE - 1);
    check("R3 read restarts", 8'(raw_o), 8'h0);
    ticks(1);
    check("R3 full interval after read", 8'(raw_o), 8'h1);
  endtask

  task automatic t_rearm();
    ticks(2 * IDLE);
    wr_clr(4'b0001);
    check("R5 timeout cleared", 8'(raw_o), 8'h0);
    ticks(IDLE - 1);
    check("R7 no early refire", 8'(raw_o), 8'h0);
    ticks(1);
    check("R7 refire after interval", 8'(raw_o), 8'h1);
    fifo_empty = 1'b1; step();
    check("R4 drained", 8'(raw_o), 8'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    step();
    t_reset();
    t_events();
    t_w1c();
    t_timeout();
    t_restart();
    t_rearm();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule